// File: doc/BRIEF.md
# Pre/Post-Trigger Sample Capture Controller

This block records a stream of 8-bit samples, one on every clock cycle, into an on-chip ring buffer. The write address comes from a free-running counter that wraps around the buffer. Once armed, the block keeps writing without a break, so the buffer always holds the most recent history. A trigger unit watches each incoming sample. When the programmed condition is met, the block notes where the trigger sample landed and then lets a programmed number of further samples in before it freezes the buffer. The result is a window that holds samples from both before and after the event.

A trigger is taken only after a programmed minimum number of samples has been stored since arming. Three trigger sources are available: a level test of the sample against a threshold, a threshold crossing between two consecutive samples, and a 256-entry one-bit lookup table indexed by the sample value. A host side sets the configuration while the block is idle, arms it, can force it to stop, and reads the frozen window back. The readout starts at the trigger address less the pre-trigger depth and steps forward by one address on each read strobe. Reads are refused while a capture is running, so the host never competes with the writer for the memory.

The address width `ADDR_W` is a parameter. A build with 16 gives the full 65536-entry buffer. The default is smaller so that elaboration stays light.

Top module: `trig_capture_top`

## Requirements
- R1: After reset the state output is 0 (idle), `trig_addr` is 0 and `rd_valid` is 0. All configuration fields (mode, sense, threshold, pre depth, post count, lookup table) are 0, so arming without any configuration fires on the first sample and finishes at once.
- R2: On `cmd_arm` accepted in idle (state 0) or done (state 3), the state becomes armed (state 1) and the write address is cleared. While armed or triggered (state 2), the k-th sample after arming (k from 0) is written at address k mod 2^ADDR_W, one sample per clock.
- R3: While armed, a trigger condition is ignored on any sample that arrives before the programmed pre depth of samples has been written since arming.
- R4: Mode 0 (level, select 0 data bits [1:0]=0): with sense bit [2]=0 it fires when the sample is greater than or equal to the threshold, and with sense 1 it fires when the sample is less than the threshold.
- R5: Mode 1 (edge): with sense 0 it fires when the previous stored sample was below the threshold and the current one is at or above it. With sense 1 it fires on the opposite crossing. The first sample after arming never fires.
- R6: Mode 2 (table): it fires when the lookup table bit addressed by the current sample value is 1. Table bits are written with `pat_we`, `pat_addr` and `pat_bit`.
- R7: The trigger sample's address is latched in `trig_addr`. Exactly the post count (select 3) of further samples is then written, after which the state becomes done and writing stops. With a post count of 0 the block goes to done directly after the trigger sample.
- R8: `cmd_stop` while armed or triggered moves the block to done on the next clock, and no sample is written on that clock. When stopped from armed, `trig_addr` is the address of the last sample written.
- R9: `rd_strobe` and `rd_start` have effect only in done. Outside done, `rd_valid` stays 0.
- R10: In done, `rd_start` sets the read address to (`trig_addr` − pre depth) mod 2^ADDR_W. Each `rd_strobe` returns the word at the read address on `rd_data` with `rd_valid` high on the next cycle, and then advances the read address by one, wrapping.
- R11: Writes to the mode, sense, threshold (select 1), pre depth (select 2), post count and lookup table are ignored unless the state is idle. `cmd_idle` returns the block to idle from any state.
- R12: Mode 3 never fires, so the capture runs until it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 8 | Sample taken this cycle |
| cmd_arm | input | 1 | Clear the write address and start capture |
| cmd_stop | input | 1 | Force the end of capture |
| cmd_idle | input | 1 | Return to idle; has priority over stop and arm |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 mode/sense, 1 threshold, 2 pre depth, 3 post count |
| cfg_wdata | input | max(ADDR_W,8) | Configuration write data |
| pat_we | input | 1 | Lookup table write strobe |
| pat_addr | input | 8 | Lookup table entry to write |
| pat_bit | input | 1 | Value of the lookup table entry |
| rd_start | input | 1 | Load the read address from trigger minus pre depth |
| rd_strobe | input | 1 | Read one word and advance |
| state | output | 2 | 0 idle, 1 armed, 2 triggered, 3 done |
| trig_addr | output | ADDR_W | Address of the trigger sample |
| rd_data | output | 8 | Read word |
| rd_valid | output | 1 | `rd_data` is fresh this cycle |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 64-word ring. With that size, runs of a few hundred samples wrap the write address several times, so the ring arithmetic of the readout start and of the forced-stop address can be checked in short runs. The post-trigger window can then cross the top of the buffer, and a window of pre depth plus post count plus one that nearly fills the ring can still be read back and compared word by word against the driven ramp. The 8-bit sample path and the 256-entry table keep their fixed sizes, so the level, edge and table modes are exercised at their real widths.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int PAT_DEPTH = 1 << SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRIG  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    typedef enum logic [1:0] {
        TM_LEVEL = 2'd0,
        TM_EDGE  = 2'd1,
        TM_TABLE = 2'd2,
        TM_OFF   = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        CS_MODE = 2'd0,
        CS_THR  = 2'd1,
        CS_PRE  = 2'd2,
        CS_POST = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       sense;
        sample_t    thr;
    } trig_cfg_t;

    function automatic logic at_or_above(sample_t s, sample_t t);
        return s >= t;
    endfunction

    function automatic logic crossing(logic sense, logic was_hi, logic now_hi);
        return sense ? (was_hi && !now_hi) : (!was_hi && now_hi);
    endfunction
endpackage

// File: rtl/cap_cfg.sv
module cap_cfg import cap_pkg::*; #(
    parameter int ADDR_W = 11,
    parameter int CFG_W  = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_idle,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 pat_we,
    input  sample_t              pat_addr,
    input  logic                 pat_bit,
    output trig_cfg_t            tcfg,
    output logic [ADDR_W-1:0]    pre_q,
    output logic [ADDR_W-1:0]    post_q,
    output logic [PAT_DEPTH-1:0] pat_q
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcfg   <= '0;
            pre_q  <= '0;
            post_q <= '0;
        end else if (cfg_we && in_idle) begin
            unique case (sel)
                CS_MODE: begin
                    tcfg.mode  <= trig_mode_e'(cfg_wdata[1:0]);
                    tcfg.sense <= cfg_wdata[2];
                end
                CS_THR:  tcfg.thr <= cfg_wdata[SAMPLE_W-1:0];
                CS_PRE:  pre_q    <= cfg_wdata[ADDR_W-1:0];
                CS_POST: post_q   <= cfg_wdata[ADDR_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (pat_we && in_idle) begin
            pat_q[pat_addr] <= pat_bit;
        end
    end
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger import cap_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 sample_we,
    input  sample_t              sample,
    input  trig_cfg_t            tcfg,
    input  logic [PAT_DEPTH-1:0] pat_q,
    output logic                 hit
);
    logic prev_hi;
    logic prev_ok;
    logic now_hi;

    assign now_hi = at_or_above(sample, tcfg.thr);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_hi <= 1'b0;
            prev_ok <= 1'b0;
        end else if (sample_we) begin
            prev_hi <= now_hi;
            prev_ok <= 1'b1;
        end
    end

    always_comb begin
        unique case (tcfg.mode)
            TM_LEVEL: hit = tcfg.sense ? !now_hi : now_hi;
            TM_EDGE:  hit = prev_ok && crossing(tcfg.sense, prev_hi, now_hi);
            TM_TABLE: hit = pat_q[sample];
            TM_OFF:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_seq.sv
module cap_seq import cap_pkg::*; #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_arm,
    input  logic              cmd_stop,
    input  logic              cmd_idle,
    input  logic              hit,
    input  logic [ADDR_W-1:0] pre_q,
    input  logic [ADDR_W-1:0] post_q,
    output cap_state_e        st,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              arm_clr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] filled;
    logic [ADDR_W-1:0] post_left;
    logic              capturing;
    logic              gate_open;
    logic              fire;

    assign capturing = (st == ST_ARMED) || (st == ST_TRIG);
    assign wr_en     = capturing && !cmd_stop && !cmd_idle;
    assign arm_clr   = cmd_arm && !cmd_idle && ((st == ST_IDLE) || (st == ST_DONE));
    assign gate_open = filled >= pre_q;
    assign fire      = (st == ST_ARMED) && wr_en && gate_open && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wr_addr   <= '0;
            trig_addr <= '0;
            filled    <= '0;
            post_left <= '0;
        end else if (cmd_idle) begin
            st <= ST_IDLE;
        end else if (cmd_stop && capturing) begin
            st <= ST_DONE;
            if (st == ST_ARMED) trig_addr <= wr_addr - ONE;
        end else if (arm_clr) begin
            st        <= ST_ARMED;
            wr_addr   <= '0;
            trig_addr <= '0;
            filled    <= '0;
        end else begin
            unique case (st)
                ST_ARMED: begin
                    wr_addr <= wr_addr + ONE;
                    if (fire) begin
                        trig_addr <= wr_addr;
                        post_left <= post_q;
                        st        <= (post_q == '0) ? ST_DONE : ST_TRIG;
                    end else if (!gate_open) begin
                        filled <= filled + ONE;
                    end
                end
                ST_TRIG: begin
                    wr_addr   <= wr_addr + ONE;
                    post_left <= post_left - ONE;
                    if (post_left == ONE) st <= ST_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cap_mem.sv
module cap_mem import cap_pkg::*; #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  sample_t           wdata,
    input  logic              rd_load,
    input  logic              rd_step,
    input  logic [ADDR_W-1:0] rd_base,
    output sample_t           rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    sample_t           ring [DEPTH];
    logic [ADDR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (we) ring[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_load) begin
            rd_ptr   <= rd_base;
            rd_valid <= 1'b0;
        end else if (rd_step) begin
            rd_data  <= ring[rd_ptr];
            rd_ptr   <= rd_ptr + ADDR_W'(1);
            rd_valid <= 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_capture_top.sv
module trig_capture_top import cap_pkg::*; #(
    parameter int ADDR_W = 11,
    localparam int CFG_W = (ADDR_W > SAMPLE_W) ? ADDR_W : SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                cmd_arm,
    input  logic                cmd_stop,
    input  logic                cmd_idle,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                pat_we,
    input  logic [SAMPLE_W-1:0] pat_addr,
    input  logic                pat_bit,
    input  logic                rd_start,
    input  logic                rd_strobe,
    output logic [1:0]          state,
    output logic [ADDR_W-1:0]   trig_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                rd_valid
);
    cap_state_e           st;
    trig_cfg_t            tcfg;
    logic [ADDR_W-1:0]    pre_q;
    logic [ADDR_W-1:0]    post_q;
    logic [PAT_DEPTH-1:0] pat_q;
    logic [ADDR_W-1:0]    wr_addr;
    logic                 wr_en;
    logic                 arm_clr;
    logic                 hit;
    logic                 in_done;

    assign state   = st;
    assign in_done = (st == ST_DONE);

    cap_cfg #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .in_idle   (st == ST_IDLE),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pat_we    (pat_we),
        .pat_addr  (pat_addr),
        .pat_bit   (pat_bit),
        .tcfg      (tcfg),
        .pre_q     (pre_q),
        .post_q    (post_q),
        .pat_q     (pat_q)
    );

    cap_trigger u_trig (
        .clk       (clk),
        .rst       (rst),
        .clr       (arm_clr),
        .sample_we (wr_en),
        .sample    (sample_in),
        .tcfg      (tcfg),
        .pat_q     (pat_q),
        .hit       (hit)
    );

    cap_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_arm   (cmd_arm),
        .cmd_stop  (cmd_stop),
        .cmd_idle  (cmd_idle),
        .hit       (hit),
        .pre_q     (pre_q),
        .post_q    (post_q),
        .st        (st),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .trig_addr (trig_addr),
        .arm_clr   (arm_clr)
    );

    cap_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (sample_in),
        .rd_load  (rd_start && in_done),
        .rd_step  (rd_strobe && in_done),
        .rd_base  (trig_addr - pre_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/cap_checker.sv
module cap_checker import cap_pkg::*; #(
    parameter int ADDR_W = 11
) (
    input logic                 clk,
    input logic                 rst,
    input cap_state_e           st,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 cmd_arm,
    input logic                 cmd_stop,
    input logic                 cmd_idle,
    input logic                 rd_valid,
    input trig_cfg_t            tcfg,
    input logic [ADDR_W-1:0]    pre_q,
    input logic [ADDR_W-1:0]    post_q,
    input logic [PAT_DEPTH-1:0] pat_q
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st == ST_IDLE));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ARMED || st == ST_TRIG) && !cmd_stop && !cmd_idle)
        |=> (wr_addr == ADDR_W'($past(wr_addr) + 1)));

    assert_trig_path_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRIG && !cmd_idle) |=> (st == ST_TRIG || st == ST_DONE));

    assert_done_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !cmd_arm && !cmd_idle) |=> (st == ST_DONE && $stable(wr_addr)));

    assert_force_stop_R8: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ARMED || st == ST_TRIG) && cmd_stop && !cmd_idle) |=> (st == ST_DONE));

    assert_read_locked_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(st) == ST_DONE));

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> ($stable(tcfg) && $stable(pre_q) && $stable(post_q) && $stable(pat_q)));

    assert_off_never_R12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && tcfg.mode == TM_OFF && !cmd_stop && !cmd_idle) |=> (st == ST_ARMED));
endmodule

bind trig_capture_top cap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .wr_addr  (wr_addr),
    .cmd_arm  (cmd_arm),
    .cmd_stop (cmd_stop),
    .cmd_idle (cmd_idle),
    .rd_valid (rd_valid),
    .tcfg     (tcfg),
    .pre_q    (pre_q),
    .post_q   (post_q),
    .pat_q    (pat_q)
);

// File: tb/test_trig_capture_top.sv
module test_trig_capture_top;
    localparam int AW = 6;
    localparam int NV = 7;

    typedef struct packed {
        logic [1:0] mode;
        logic       sense;
        logic [7:0] thr;
        logic [5:0] pre;
        logic [5:0] post;
        logic [7:0] base;
        logic [7:0] step;
        logic [7:0] pa;
        logic [7:0] pb;
        int         exp_k;
    } vec_t;

    // mode sense thr pre post base step pa pb exp_k
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 8'd40,  6'd3,  6'd4,  8'd0,   8'd8, 8'd0,  8'd0,  5},   // R4 ge
        '{2'd0, 1'b1, 8'd100, 6'd10, 6'd5,  8'd200, 8'd3, 8'd0,  8'd0,  19},  // R4 lt
        '{2'd0, 1'b1, 8'd100, 6'd7,  6'd2,  8'd10,  8'd1, 8'd0,  8'd0,  7},   // R3 gate
        '{2'd1, 1'b0, 8'd128, 6'd0,  6'd6,  8'd100, 8'd5, 8'd0,  8'd0,  6},   // R5 rise
        '{2'd1, 1'b1, 8'd50,  6'd20, 6'd10, 8'd0,   8'd7, 8'd0,  8'd0,  37},  // R5 fall
        '{2'd0, 1'b0, 8'd250, 6'd30, 6'd30, 8'd0,   8'd1, 8'd0,  8'd0,  250}, // R2 R10 wrap
        '{2'd2, 1'b0, 8'd0,   6'd4,  6'd3,  8'd0,   8'd7, 8'd14, 8'd77, 11}   // R6 table
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    sample_in = '0;
    logic          cmd_arm = 1'b0, cmd_stop = 1'b0, cmd_idle = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          pat_we = 1'b0;
    logic [7:0]    pat_addr = '0;
    logic          pat_bit = 1'b0;
    logic          rd_start = 1'b0, rd_strobe = 1'b0;
    logic [1:0]    state;
    logic [AW-1:0] trig_addr;
    logic [7:0]    rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trig_capture_top #(.ADDR_W(AW)) i_trig_capture_top (
        .clk(clk), .rst(rst), .sample_in(sample_in),
        .cmd_arm(cmd_arm), .cmd_stop(cmd_stop), .cmd_idle(cmd_idle),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_bit(pat_bit),
        .rd_start(rd_start), .rd_strobe(rd_strobe),
        .state(state), .trig_addr(trig_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] sv(input vec_t v, input int k);
        return 8'(int'(v.base) + int'(v.step) * k);
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pat_write(input logic [7:0] a);
        pat_we = 1'b1; pat_addr = a; pat_bit = 1'b1;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit do_cfg, input string tag);
        int done_at;
        int cnt;
        cmd_idle = 1'b1;
        @(negedge clk);
        cmd_idle = 1'b0;
        if (do_cfg) begin
            cfg_write(2'd0, {5'd0, v.sense, v.mode});
            cfg_write(2'd1, v.thr);
            cfg_write(2'd2, {2'd0, v.pre});
            cfg_write(2'd3, {2'd0, v.post});
            if (v.mode == 2'd2) begin
                pat_write(v.pa);
                pat_write(v.pb);
            end
        end
        cmd_arm = 1'b1;
        @(negedge clk);
        cmd_arm = 1'b0;
        sample_in = sv(v, 0);
        done_at = -1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            sample_in = sv(v, i);
            if (state == 2'd3) begin
                done_at = i;
                break;
            end
        end
        chk({tag, " R7 samples until done"}, done_at, v.exp_k + int'(v.post) + 1);
        chk({tag, " R7 trig_addr"}, int'(trig_addr), v.exp_k % (1 << AW));
        cnt = int'(v.pre) + int'(v.post) + 1;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        rd_strobe = 1'b1;
        for (int j = 0; j < cnt; j++) begin
            @(negedge clk);
            if (j == cnt - 1) rd_strobe = 1'b0;
            chk({tag, " R10 rd_valid"}, int'(rd_valid), 1);
            chk({tag, " R10 rd_data"}, int'(rd_data), int'(sv(v, v.exp_k - int'(v.pre) + j)));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        vec_t dflt;
        vec_t ramp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(state), 0);
        chk("R1 trig_addr", int'(trig_addr), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);

        // R1 zero configuration: fires on first sample, post 0 (R7)
        dflt = '{2'd0, 1'b0, 8'd0, 6'd0, 6'd0, 8'd5, 8'd1, 8'd0, 8'd0, 0};
        run_vec(dflt, 1'b0, "R1 default");

        for (int v = 0; v < NV; v++) begin
            run_vec(VECS[v], 1'b1, $sformatf("vec%0d", v));
        end

        // Mode 3 capture, config lockout, read lockout, forced stop
        ramp = '{2'd3, 1'b0, 8'd0, 6'd0, 6'd0, 8'd0, 8'd1, 8'd0, 8'd0, 0};
        cmd_idle = 1'b1;
        @(negedge clk);
        cmd_idle = 1'b0;
        cfg_write(2'd0, 8'd3);
        cfg_write(2'd2, 8'd0);
        cmd_arm = 1'b1;
        @(negedge clk);
        cmd_arm = 1'b0;
        sample_in = 8'd0;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            sample_in = sv(ramp, i);
            cfg_we = 1'b0;
            rd_strobe = 1'b0;
            if (i == 40) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd0; // R11 level ge 0 attempt
            end
            if (i == 60) rd_strobe = 1'b1;
            if (i == 61) chk("R9 rd_valid while armed", int'(rd_valid), 0);
        end
        chk("R12 still armed", int'(state), 1);
        chk("R11 mode write ignored", int'(state), 1);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        sample_in = 8'd200;
        chk("R8 state done", int'(state), 3);
        chk("R8 trig_addr last written", int'(trig_addr), 99 % (1 << AW));
        repeat (3) @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        rd_strobe = 1'b1;
        @(negedge clk);
        chk("R8 read last sample", int'(rd_data), 99);
        @(negedge clk);
        chk("R8 no write after stop", int'(rd_data), 36);
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R2 wrapped address", int'(rd_data), 37);
        @(negedge clk);
        chk("R9 rd_valid drops", int'(rd_valid), 0);
        summary();
    end
endmodule